// File: doc/BRIEF.md
# Prescaled PWM Channel with Interrupt Vector

This block drives one pulse-width-modulated output. A base prescaler divides the system clock by 2 or 3. A 3-bit clock-select code then picks a further ratio from the set ×1, ×2, ×4, ×8, ×16, ×32, ×64 and ×256. There is deliberately no ×128 step. The resulting tick clocks a counter that runs from 1 up to the active period value. The output stays high while the count is at or below the active pulse width, so the output frequency is the system clock divided by (base × ratio × period).

Software loads the period and width through a small write port. These writes land in shadow registers, which are copied into the active pair only when a period completes, so a period is never cut short or stretched. At the end of each period the channel can raise an interrupt request. When that request is acknowledged, the channel returns an 8-bit vector. The vector is a 2-bit base field in bits 7:6 followed by the channel's 6-bit number. The channel also exposes a 4-bit arbitration priority for an external arbiter.

Top module: `pwm_vec_chan`

## Requirements
- R1: A synchronous reset drives pwmOut, irqReq, vecValid, vecOut and arbPrio to zero and selects the divide-by-2 base with the ×1 ratio. If only period and width are then written, one period lasts period×2 system clocks.
- R2: Bit 0 of the config word (wrAddr 0) selects the base prescaler: 0 gives divide-by-2 and 1 gives divide-by-3.
- R3: Config bits 3:1 select the tick ratio over the base: codes 0..7 give ×1, ×2, ×4, ×8, ×16, ×32, ×64 and ×256 (code 7 is ×256, not ×128).
- R4: With period P≥1 (wrAddr 1), the output repeats every P×base×ratio system clocks.
- R5: With width W (wrAddr 2) and 1≤W<P, the output is high for W×base×ratio clocks of each period. W=0 holds the output low, and W≥P holds it high.
- R6: Period and width writes take effect only from the next period start; the period in progress keeps its old values.
- R7: When config bit 4 is 1, irqReq rises at the end of every period and then stays high until acknowledged. When bit 4 is 0, no new request is raised.
- R8: An irqAck cycle while irqReq is high clears the request. In the following cycle it produces a one-cycle vecValid with vecOut = {config bits 6:5, 6-bit channel number}. An irqAck with no pending request produces no vecValid.
- R9: arbPrio equals {config bit 11, config bits 10:8}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 config, 1 period, 2 width |
| wrData | input | 16 | Write data |
| irqAck | input | 1 | Interrupt acknowledge cycle |
| pwmOut | output | 1 | PWM output |
| irqReq | output | 1 | Pending interrupt request |
| vecValid | output | 1 | Vector presented this cycle |
| vecOut | output | 8 | Interrupt vector |
| arbPrio | output | 4 | Arbitration priority |

## Verification
The hardest situation to reach is a new period or width written in the middle of a running period. That write must not disturb the current cycle. The bench waits for a rising edge of pwmOut, writes a different width while the output is still high, and measures that high phase against the old width. It then measures the next phase against the new width. The top clock code is driven with a period of 2 so that the ×256 ratio, and not ×128, shows up as a 1024-clock period.

// File: rtl/pwm_vec_pkg.sv
package pwm_vec_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PER = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PW  = 2'd2;

  typedef struct packed {
    logic tick;
    logic wrPeriod;
    logic wrWidth;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_vec_ctrl.sv
module pwm_vec_ctrl
  import pwm_vec_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8,
  parameter int CHAN_ID = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqAck,
  input  logic              periodEnd,
  output pwmStrobe_t        strobe,
  output logic              irqReq,
  output logic [7:0]        vecOut,
  output logic              vecValid,
  output logic [3:0]        arbPrio
);
  localparam logic [5:0] CHAN_NUM = 6'(CHAN_ID);
  localparam int SEL_W = 3;

  logic             cfgDiv3;
  logic [SEL_W-1:0] cfgClkSel;
  logic             cfgIrqEn;
  logic [1:0]       cfgVecBase;
  logic [2:0]       cfgModPrio;
  logic             cfgChanPrio;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgDiv3     <= 1'b0;
      cfgClkSel   <= '0;
      cfgIrqEn    <= 1'b0;
      cfgVecBase  <= '0;
      cfgModPrio  <= '0;
      cfgChanPrio <= 1'b0;
    end else if (wrEn && wrAddr == ADDR_CFG) begin
      cfgDiv3     <= wrData[0];
      cfgClkSel   <= wrData[3:1];
      cfgIrqEn    <= wrData[4];
      cfgVecBase  <= wrData[6:5];
      cfgModPrio  <= wrData[10:8];
      cfgChanPrio <= wrData[11];
    end
  end

  // base prescaler: divide by 2 or 3
  logic [1:0] baseCnt;
  logic [1:0] baseMax;
  logic       baseTick;
  assign baseMax  = cfgDiv3 ? 2'd2 : 2'd1;
  assign baseTick = (baseCnt >= baseMax);

  always_ff @(posedge clk) begin
    if (rst)           baseCnt <= '0;
    else if (baseTick) baseCnt <= '0;
    else               baseCnt <= baseCnt + 2'd1;
  end

  // ratio table: power-of-two taps, top code jumps to the widest tap
  logic [DIV_W-1:0] ratioM1 [2**SEL_W];
  generate
    for (genvar g = 0; g < 2**SEL_W; g++) begin : g_tap
      if (g == 2**SEL_W - 1) begin : g_top
        assign ratioM1[g] = {DIV_W{1'b1}};
      end else begin : g_pow
        assign ratioM1[g] = DIV_W'((1 << g) - 1);
      end
    end
  endgenerate

  logic [DIV_W-1:0] divCnt;
  logic             divWrap;
  assign divWrap = (divCnt >= ratioM1[cfgClkSel]);

  always_ff @(posedge clk) begin
    if (rst)           divCnt <= '0;
    else if (baseTick) divCnt <= divWrap ? '0 : divCnt + 1'b1;
  end

  always_comb begin
    strobe.tick     = baseTick && divWrap;
    strobe.wrPeriod = wrEn && (wrAddr == ADDR_PER);
    strobe.wrWidth  = wrEn && (wrAddr == ADDR_PW);
  end

  // interrupt flag and vector
  always_ff @(posedge clk) begin
    if (rst)                        irqReq <= 1'b0;
    else if (periodEnd && cfgIrqEn) irqReq <= 1'b1;
    else if (irqAck)                irqReq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else if (irqAck && irqReq) begin
      vecValid <= 1'b1;
      vecOut   <= {cfgVecBase, CHAN_NUM};
    end else begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end
  end

  assign arbPrio = {cfgChanPrio, cfgModPrio};

  a_r2_base_spacing: assert property (@(posedge clk) disable iff (rst)
    baseTick |=> !baseTick);
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (irqReq && !irqAck) |=> irqReq);
  a_r8_vec_after_ack: assert property (@(posedge clk) disable iff (rst)
    vecValid |-> $past(irqAck));
  a_r8_vec_chan: assert property (@(posedge clk) disable iff (rst)
    vecValid |-> (vecOut[5:0] == CHAN_NUM));
endmodule

// File: rtl/pwm_vec_dp.sv
module pwm_vec_dp
  import pwm_vec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic             pwmOut,
  output logic             periodEnd
);
  logic [CNT_W-1:0] bufPer, bufPw;
  logic [CNT_W-1:0] actPer, actPw;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             atEnd;

  assign atEnd     = (cnt >= actPer);
  assign cntNext   = cnt + 1'b1;
  assign periodEnd = strobe.tick && atEnd && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bufPer <= '0;
      bufPw  <= '0;
    end else begin
      if (strobe.wrPeriod) bufPer <= wrData;
      if (strobe.wrWidth)  bufPw  <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      actPer <= '0;
      actPw  <= '0;
      pwmOut <= 1'b0;
    end else if (strobe.tick) begin
      if (atEnd) begin
        cnt    <= CNT_W'(1);
        actPer <= bufPer;
        actPw  <= bufPw;
        pwmOut <= (bufPw != '0);
      end else begin
        cnt    <= cntNext;
        pwmOut <= (cntNext <= actPw);
      end
    end
  end

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (actPer != '0) |-> (cnt <= actPer));
  a_r6_out_on_tick: assert property (@(posedge clk) disable iff (rst)
    !strobe.tick |=> $stable(pwmOut));
  a_r5_zero_low: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && !atEnd && actPw == '0) |=> !pwmOut);
endmodule

// File: rtl/pwm_vec_chan.sv
module pwm_vec_chan
  import pwm_vec_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 8,
  parameter int CHAN_ID = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             irqAck,
  output logic             pwmOut,
  output logic             irqReq,
  output logic             vecValid,
  output logic [7:0]       vecOut,
  output logic [3:0]       arbPrio
);
  pwmStrobe_t strobe;
  logic       periodEnd;

  pwm_vec_ctrl #(.DATA_W(CNT_W), .DIV_W(DIV_W), .CHAN_ID(CHAN_ID)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqAck(irqAck), .periodEnd(periodEnd), .strobe(strobe),
    .irqReq(irqReq), .vecOut(vecOut), .vecValid(vecValid), .arbPrio(arbPrio)
  );

  pwm_vec_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .pwmOut(pwmOut), .periodEnd(periodEnd)
  );
endmodule

// File: tb/sim_pwm_vec_chan.sv
module sim_pwm_vec_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        irqAck = 1'b0;
  logic        pwmOut, irqReq, vecValid;
  logic [7:0]  vecOut;
  logic [3:0]  arbPrio;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pwm_vec_chan u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqAck(irqAck), .pwmOut(pwmOut), .irqReq(irqReq), .vecValid(vecValid),
    .vecOut(vecOut), .arbPrio(arbPrio)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cfgWord(bit div3, int sel, bit irqEn,
                                          int base, int modPrio, bit chanPrio);
    return {4'b0, chanPrio, 3'(modPrio), 1'b0, 2'(base), irqEn, 3'(sel), div3};
  endfunction

  task automatic writeReg(logic [1:0] addr, logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(output int hi, output int per);
    int guard = 0;
    hi = 0; per = 0;
    while (pwmOut !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    while (pwmOut !== 1'b1 && guard < 8000) begin @(negedge clk); guard++; end
    while (pwmOut === 1'b1 && guard < 12000) begin
      hi++; per++; @(negedge clk); guard++;
    end
    while (pwmOut === 1'b0 && guard < 16000) begin
      per++; @(negedge clk); guard++;
    end
  endtask

  task automatic setupAndMeasure(string req, bit div3, int sel, int p, int w,
                                 int expHi, int expPer);
    int hi, per;
    writeReg(2'd0, cfgWord(div3, sel, 1'b0, 0, 0, 1'b0));
    writeReg(2'd1, 16'(p));
    writeReg(2'd2, 16'(w));
    measure(hi, per);
    measure(hi, per);
    check({req, " high time"}, hi, expHi);
    check({req, " period"}, per, expPer);
  endtask

  task automatic t_reset();
    int hi, per;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pwmOut", int'(pwmOut), 0);
    check("R1 irqReq", int'(irqReq), 0);
    check("R1 vecValid", int'(vecValid), 0);
    check("R1 vecOut", int'(vecOut), 0);
    check("R1 arbPrio", int'(arbPrio), 0);
    rst = 1'b0;
    writeReg(2'd1, 16'd5);
    writeReg(2'd2, 16'd2);
    measure(hi, per);
    measure(hi, per);
    check("R1 default high", hi, 4);
    check("R1 default period", per, 10);
  endtask

  task automatic t_ratios();
    setupAndMeasure("R2 R3 R4 R5 div3 x4", 1'b1, 2, 5, 3, 36, 60);
    setupAndMeasure("R2 R3 R4 div3 x2", 1'b1, 1, 3, 1, 6, 18);
    setupAndMeasure("R3 R4 div2 x64", 1'b0, 6, 2, 1, 128, 256);
    setupAndMeasure("R3 R4 div2 code7 x256", 1'b0, 7, 2, 1, 512, 1024);
    setupAndMeasure("R4 R5 div2 x1 P9", 1'b0, 0, 9, 4, 8, 18);
  endtask

  task automatic t_constant();
    int toggles;
    logic last;
    writeReg(2'd0, cfgWord(1'b0, 0, 1'b0, 0, 0, 1'b0));
    writeReg(2'd1, 16'd4);
    writeReg(2'd2, 16'd0);
    repeat (30) @(negedge clk);
    toggles = 0; last = pwmOut;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwmOut !== last) toggles++;
      last = pwmOut;
    end
    check("R5 width zero level", int'(pwmOut), 0);
    check("R5 width zero toggles", toggles, 0);
    writeReg(2'd2, 16'd9);
    repeat (30) @(negedge clk);
    toggles = 0; last = pwmOut;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwmOut !== last) toggles++;
      last = pwmOut;
    end
    check("R5 width over period level", int'(pwmOut), 1);
    check("R5 width over period toggles", toggles, 0);
  endtask

  task automatic t_buffer();
    int hi, per, guard;
    writeReg(2'd0, cfgWord(1'b0, 0, 1'b0, 0, 0, 1'b0));
    writeReg(2'd1, 16'd10);
    writeReg(2'd2, 16'd3);
    measure(hi, per);
    guard = 0;
    while (pwmOut !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    while (pwmOut !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
    // mid-period: output just went high with width 3
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 16'd7;
    hi = 1;
    @(negedge clk);
    wrEn = 1'b0;
    while (pwmOut === 1'b1 && guard < 600) begin hi++; @(negedge clk); guard++; end
    check("R6 current period keeps old width", hi, 6);
    measure(hi, per);
    check("R6 next period new width", hi, 14);
    check("R6 period unchanged", per, 20);
  endtask

  task automatic t_irq();
    int guard;
    writeReg(2'd1, 16'd3);
    writeReg(2'd2, 16'd1);
    writeReg(2'd0, cfgWord(1'b0, 0, 1'b1, 2, 5, 1'b1));
    check("R9 arbPrio", int'(arbPrio), 13);
    guard = 0;
    while (irqReq !== 1'b1 && guard < 40) begin @(negedge clk); guard++; end
    check("R7 request raised", int'(irqReq), 1);
    repeat (30) @(negedge clk);
    check("R7 request held", int'(irqReq), 1);
    writeReg(2'd0, cfgWord(1'b0, 0, 1'b0, 2, 5, 1'b1));
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    check("R8 vecValid after ack", int'(vecValid), 1);
    check("R8 vector value", int'(vecOut), 8'h88);
    check("R8 request cleared", int'(irqReq), 0);
    @(negedge clk);
    check("R8 vecValid one cycle", int'(vecValid), 0);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    check("R8 ack without request", int'(vecValid), 0);
    repeat (40) @(negedge clk);
    check("R7 disabled no request", int'(irqReq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ratios();
    t_constant();
    t_buffer();
    t_irq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule